// File: doc/BRIEF.md
# Multi-Mode Funnel Barrel Shifter

This block is a purely combinational shifter that handles five operations on an N-bit word: logical and arithmetic shifts to the right, a logical shift to the left, and rotation in either direction. All five run through one shared right-only funnel. A front stage builds a window of 2N-1 bits and an offset. The funnel then returns the N consecutive window bits that start at that offset. The operation is set only by how the window is filled and which offset is used.

Left operations do not need a left-shifting path. They place the data word in the top of the window and use the bitwise complement of the amount, which equals (N-1)-k. A parameter picks one of two funnel styles. The first decodes the offset into one-hot select lines, so each output bit is an OR of window bits gated by a single select. The second uses log2(N) rows of 2:1 multiplexers, and the row for bit i moves the window by 2^i. Both styles produce the same result for every input.

Top module: `bshift_unit`

## Requirements
- R1: With op_sel = 3'b000 (logical right), result equals data_in shifted right by amount, and zeros fill the vacated high bits.
- R2: With op_sel = 3'b001 (arithmetic right), result equals data_in shifted right by amount, and copies of data_in[N-1] fill the vacated high bits.
- R3: With op_sel = 3'b010 (logical left), result equals data_in shifted left by amount, and zeros fill the vacated low bits.
- R4: With op_sel = 3'b011 (rotate left), result equals data_in rotated toward the MSB by amount. Bits leaving the MSB re-enter at bit 0.
- R5: With op_sel = 3'b100 (rotate right), result equals data_in rotated toward the LSB by amount. Bits leaving bit 0 re-enter at the MSB.
- R6: With op_sel = 3'b101, 3'b110 or 3'b111, result equals data_in whatever the amount.
- R7: With amount = 0, result equals data_in for every op_sel value.
- R8: The decoded-select style (CORE_STYLE = 0) and the mux-row style (CORE_STYLE = 1) give identical results for every data_in, amount and op_sel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_in | input | N | Word to shift or rotate |
| amount | input | AW = log2(N) | Shift or rotate distance, 0 to N-1 |
| op_sel | input | 3 | Operation code (see R1 to R6) |
| result | output | N | Shifted or rotated word |

## Verification
The bench builds the block four times: both core styles at N = 4 and both at N = 8. At N = 4 the whole space is small (16 words, 4 amounts, 8 codes), so every combination is applied to both styles and compared against a bench reference. At N = 8 the bench adds a seeded random sweep and directed words such as alternating bits, a lone MSB and all ones at the largest amount. This exercises the three-row mux chain and the sign fill across a wider window.

// File: rtl/bshift_pkg.sv
package bshift_pkg;

    typedef enum logic [2:0] {
        OP_SRL = 3'b000,
        OP_SRA = 3'b001,
        OP_SLL = 3'b010,
        OP_ROL = 3'b011,
        OP_ROR = 3'b100
    } bshift_op_e;

    localparam int STYLE_DECODED = 0;
    localparam int STYLE_MUXROWS = 1;

endpackage

// File: rtl/bshift_window_fill.sv
module bshift_window_fill #(
    parameter int N   = 4,
    parameter int AW  = $clog2(N),
    parameter int WIN = 2 * N - 1
) (
    input  logic [N-1:0]   data_in,
    input  logic [AW-1:0]  amount,
    input  logic [2:0]     op_sel,
    output logic [WIN-1:0] win,
    output logic [AW-1:0]  offs
);
    import bshift_pkg::*;

    logic [WIN-1:0] win_d;
    logic [AW-1:0]  offs_d;

    always_comb begin
        win_d  = {{(N-1){1'b0}}, data_in};
        offs_d = '0;
        case (op_sel)
            OP_SRL: begin
                win_d  = {{(N-1){1'b0}}, data_in};
                offs_d = amount;
            end
            OP_SRA: begin
                win_d  = {{(N-1){data_in[N-1]}}, data_in};
                offs_d = amount;
            end
            OP_SLL: begin
                win_d  = {data_in, {(N-1){1'b0}}};
                offs_d = ~amount;
            end
            OP_ROL: begin
                win_d  = {data_in, data_in[N-1:1]};
                offs_d = ~amount;
            end
            OP_ROR: begin
                win_d  = {data_in[N-2:0], data_in};
                offs_d = amount;
            end
            default: begin
                win_d  = {{(N-1){1'b0}}, data_in};
                offs_d = '0;
            end
        endcase
    end

    assign win  = win_d;
    assign offs = offs_d;

endmodule

// File: rtl/bshift_core_dec.sv
module bshift_core_dec #(
    parameter int N   = 4,
    parameter int AW  = $clog2(N),
    parameter int WIN = 2 * N - 1
) (
    input  logic [WIN-1:0] win,
    input  logic [AW-1:0]  offs,
    output logic [N-1:0]   dout
);
    logic [N-1:0] sel_d;
    logic [N-1:0] dout_d;

    always_comb begin
        sel_d       = '0;
        sel_d[offs] = 1'b1;
    end

    always_comb begin
        for (int j = 0; j < N; j++) begin
            dout_d[j] = 1'b0;
            for (int t = 0; t < N; t++) begin
                dout_d[j] = dout_d[j] | (sel_d[t] & win[j+t]);
            end
        end
    end

    assign dout = dout_d;

endmodule

// File: rtl/bshift_core_mux.sv
module bshift_core_mux #(
    parameter int N   = 4,
    parameter int AW  = $clog2(N),
    parameter int WIN = 2 * N - 1
) (
    input  logic [WIN-1:0] win,
    input  logic [AW-1:0]  offs,
    output logic [N-1:0]   dout
);
    logic [WIN-1:0] stage_q [0:AW];

    assign stage_q[0] = win;

    for (genvar i = 0; i < AW; i++) begin : g_row
        logic [WIN-1:0] moved_d;
        assign moved_d        = stage_q[i] >> (2 ** i);
        assign stage_q[i + 1] = offs[i] ? moved_d : stage_q[i];
    end

    assign dout = stage_q[AW][N-1:0];

    // R7
    always_comb begin
        if (!$isunknown(offs) && offs == '0) begin
            rows_idle_chk: assert (stage_q[AW] == win)
                else $error("mux rows altered window at zero offset");
        end
    end

endmodule

// File: rtl/bshift_unit.sv
module bshift_unit #(
    parameter int N          = 4,
    parameter int CORE_STYLE = 0,
    parameter int AW         = $clog2(N)
) (
    input  logic [N-1:0]  data_in,
    input  logic [AW-1:0] amount,
    input  logic [2:0]    op_sel,
    output logic [N-1:0]  result
);
    import bshift_pkg::*;

    localparam int WIN = 2 * N - 1;

    logic [WIN-1:0] win_d;
    logic [AW-1:0]  offs_d;
    logic [N-1:0]   core_d;

    bshift_window_fill #(.N(N), .AW(AW), .WIN(WIN)) u_fill (
        .data_in (data_in),
        .amount  (amount),
        .op_sel  (op_sel),
        .win     (win_d),
        .offs    (offs_d)
    );

    if (CORE_STYLE == STYLE_MUXROWS) begin : g_mux
        bshift_core_mux #(.N(N), .AW(AW), .WIN(WIN)) u_core (
            .win  (win_d),
            .offs (offs_d),
            .dout (core_d)
        );
    end else begin : g_dec
        bshift_core_dec #(.N(N), .AW(AW), .WIN(WIN)) u_core (
            .win  (win_d),
            .offs (offs_d),
            .dout (core_d)
        );
    end

    assign result = core_d;

    localparam logic [N-1:0] ONES = '1;

    always_comb begin
        if (!$isunknown({data_in, amount, op_sel, result})) begin
            // R1
            srl_zero_fill_chk: assert (op_sel != OP_SRL || (result & ~(ONES >> amount)) == '0)
                else $error("logical right left nonzero high bits");
            // R2
            sra_sign_keep_chk: assert (op_sel != OP_SRA || result[N-1] == data_in[N-1])
                else $error("arithmetic right lost sign");
            // R3
            sll_zero_fill_chk: assert (op_sel != OP_SLL || (result & ~(ONES << amount)) == '0)
                else $error("logical left left nonzero low bits");
            // R4
            rol_pop_chk: assert (op_sel != OP_ROL || $countones(result) == $countones(data_in))
                else $error("rotate left changed bit count");
            // R5
            ror_pop_chk: assert (op_sel != OP_ROR || $countones(result) == $countones(data_in))
                else $error("rotate right changed bit count");
            // R6
            spare_code_chk: assert (op_sel <= 3'b100 || result == data_in)
                else $error("spare code altered data");
            // R7
            zero_amount_chk: assert (amount != '0 || result == data_in)
                else $error("zero amount altered data");
        end
    end

endmodule

// File: tb/bshift_unit_test.sv
module bshift_unit_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    int vectors = 0;
    int misses  = 0;

    logic [3:0] d4;
    logic [1:0] a4;
    logic [2:0] o4;
    logic [3:0] r4_dec, r4_mux;

    logic [7:0] d8;
    logic [2:0] a8;
    logic [2:0] o8;
    logic [7:0] r8_dec, r8_mux;

    bshift_unit #(.N(4), .CORE_STYLE(0)) uut (
        .data_in(d4), .amount(a4), .op_sel(o4), .result(r4_dec));
    bshift_unit #(.N(4), .CORE_STYLE(1)) uut_mux4 (
        .data_in(d4), .amount(a4), .op_sel(o4), .result(r4_mux));
    bshift_unit #(.N(8), .CORE_STYLE(0)) uut_dec8 (
        .data_in(d8), .amount(a8), .op_sel(o8), .result(r8_dec));
    bshift_unit #(.N(8), .CORE_STYLE(1)) uut_mux8 (
        .data_in(d8), .amount(a8), .op_sel(o8), .result(r8_mux));

    function automatic logic [7:0] ref_model(input int n, input logic [7:0] d,
                                             input int k, input logic [2:0] op);
        logic [15:0] mask, x, r;
        mask = (16'h1 << n) - 16'h1;
        x    = {8'h00, d} & mask;
        case (op)
            3'b000: r = x >> k;
            3'b001: begin
                r = x >> k;
                if (x[n-1]) r = r | (mask & ~(mask >> k));
            end
            3'b010: r = (x << k) & mask;
            3'b011: r = ((x << k) | (x >> (n - k))) & mask;
            3'b100: r = ((x >> k) | (x << (n - k))) & mask;
            default: r = x;
        endcase
        return r[7:0];
    endfunction

    function automatic string req_tag(input int k, input logic [2:0] op);
        if (k == 0)     return "R7";
        case (op)
            3'b000: return "R1";
            3'b001: return "R2";
            3'b010: return "R3";
            3'b011: return "R4";
            3'b100: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic apply4(input logic [3:0] d, input logic [1:0] a, input logic [2:0] op);
        logic [7:0] exp;
        @(negedge clk);
        d4 = d; a4 = a; o4 = op;
        #1;
        exp = ref_model(4, {4'h0, d}, int'(a), op);
        vectors++;
        if (r4_dec !== exp[3:0] || r4_mux !== exp[3:0]) begin
            misses++;
            $display("FAIL %s/R8 N=4 d=%h k=%0d op=%0d dec=%h mux=%h expected=%h",
                     req_tag(int'(a), op), d, a, op, r4_dec, r4_mux, exp[3:0]);
        end
    endtask

    task automatic apply8(input logic [7:0] d, input logic [2:0] a, input logic [2:0] op);
        logic [7:0] exp;
        @(negedge clk);
        d8 = d; a8 = a; o8 = op;
        #1;
        exp = ref_model(8, d, int'(a), op);
        vectors++;
        if (r8_dec !== exp || r8_mux !== exp) begin
            misses++;
            $display("FAIL %s/R8 N=8 d=%h k=%0d op=%0d dec=%h mux=%h expected=%h",
                     req_tag(int'(a), op), d, a, op, r8_dec, r8_mux, exp);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        misses++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        void'($urandom(32'h1d5e_ed07));
        d4 = '0; a4 = '0; o4 = '0;
        d8 = '0; a8 = '0; o8 = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        // reset state: zero inputs give zero result (R7)
        vectors++;
        if (r4_dec !== 4'h0 || r8_mux !== 8'h00) begin
            misses++;
            $display("FAIL R7 idle actual=%h/%h expected=0/0", r4_dec, r8_mux);
        end

        // N=4 exhaustive over every code: R1..R8
        for (int op = 0; op < 8; op++)
            for (int k = 0; k < 4; k++)
                for (int d = 0; d < 16; d++)
                    apply4(4'(d), 2'(k), 3'(op));

        // N=8 directed corners
        apply8(8'h80, 3'd7, 3'b001); // R2 lone MSB, full sign fill
        apply8(8'h80, 3'd7, 3'b000); // R1 lone MSB to bit 0
        apply8(8'h01, 3'd7, 3'b010); // R3 bit 0 to MSB
        apply8(8'hFF, 3'd7, 3'b010); // R3 all ones, largest amount
        apply8(8'hA5, 3'd1, 3'b011); // R4 wrap of MSB
        apply8(8'hA5, 3'd1, 3'b100); // R5 wrap of LSB
        apply8(8'h55, 3'd4, 3'b011); // R4 half rotation
        apply8(8'h3C, 3'd5, 3'b111); // R6 spare code
        apply8(8'h3C, 3'd6, 3'b101); // R6 spare code
        apply8(8'hC3, 3'd0, 3'b001); // R7 zero amount
        apply8(8'hC3, 3'd0, 3'b010); // R7 zero amount left

        // N=8 seeded random sweep: R1..R8
        for (int i = 0; i < 4000; i++)
            apply8(8'($urandom), 3'($urandom), 3'($urandom));

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule